// File: doc/BRIEF.md
# Intra 16x16 Prediction Mode Decision

This block chooses the cheapest of three whole-block intra predictors for a square block of pixels: vertical, where each column copies the pixel above the block; horizontal, where each row copies the pixel to its left; and DC, where every pixel takes one flat value derived from the neighbours. The cost of each predictor is the sum of absolute differences (SAD) between the source pixels and the predicted pixels, taken over the whole block.

A single start pulse captures the neighbour array, the availability word and the valid-mode mask. The flat DC value is derived at that moment. Source rows then stream in, one row of pixels per accepted transfer, and each row adds to three SAD accumulators at once. After the last row the block applies the mode mask, compares the three costs with a fixed tie preference, and raises done for one cycle. At the same time it presents the mode code and the cost of that mode. Both outputs hold until the next result.

Top module: `i16_mode_decide`

## Requirements
- R1: While reset is held and after it is released, done and row_ready are 0, best_mode is 0 and best_sad is 0.
- R2: A start pulse in the idle state captures nbr_i, avail_i and mask_i. Later changes to these inputs, and a start pulse raised while rows are still being taken, do not change the result.
- R3: row_ready is 1 from the cycle after start until the 16th row has been taken, and 0 otherwise. A row counts only in a cycle where row_valid and row_ready are both 1. Idle cycles inside the row stream are allowed. Row pixel c is at row_data bits [8c+7:8c], and rows arrive top to bottom.
- R4: The vertical cost is the SAD over all 256 pixels against the top neighbour of each pixel's column. nbr_i byte 17+c, at bits [8(17+c)+7:8(17+c)], is the top pixel of column c.
- R5: The horizontal cost is the SAD against the left neighbour of each pixel's row. The left pixel of row r is nbr_i byte 15-r, so byte 15 belongs to row 0. Byte 16 is the corner and is not used.
- R6: When avail_i bit 0 (left present) and bit 2 (top present) are both set, the DC value is (sum of the 32 left and top bytes + 16) >> 5.
- R7: When exactly one of those two bits is set, the DC value is (sum of that side's 16 bytes + 8) >> 4.
- R8: When avail_i is all zero, the DC value is 128. When avail_i is nonzero but bits 0 and 2 are both clear, the DC value is 0.
- R9: mask_i bit 0 enables vertical, bit 1 horizontal and bit 2 DC. A disabled mode enters the comparison with cost 2^30.
- R10: Vertical wins when its cost is no larger than either other cost. Otherwise horizontal wins when its cost is no larger than the DC cost. Otherwise DC wins.
- R11: done is 1 for exactly one cycle, two cycles after the edge that accepts the 16th row. best_mode and best_sad hold their values after done falls.
- R12: best_mode is 0 for vertical, 1 for horizontal and 2 for DC. best_sad is the cost of the chosen mode, including the sentinel value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a block; captures the neighbours, availability and mask |
| nbr_i | input | 264 | 33 neighbour bytes: left bottom-up (0..15), corner (16), top (17..32) |
| avail_i | input | 4 | Neighbour availability; bit 0 left, bit 2 top |
| mask_i | input | 3 | Enabled modes; bit 0 vertical, bit 1 horizontal, bit 2 DC |
| row_valid | input | 1 | A source row is offered |
| row_data | input | 128 | 16 source pixels, pixel c in byte c |
| row_ready | output | 1 | Block is taking source rows |
| done | output | 1 | One-cycle pulse when a result is presented |
| best_mode | output | 2 | Chosen mode code |
| best_sad | output | 32 | Cost of the chosen mode |

## Verification
Ties between the three costs are the hardest case to reach, because ordinary pixel data almost never gives two equal SADs. The stimulus creates them deliberately: it fills the source and every neighbour with one flat value. All three costs are then zero, and the mode mask is narrowed step by step so each rung of the preference order shows. Masking out the mode whose cost is exactly zero checks that the sentinel really knocks it out. Blocks fed with idle gaps, with a second start pulse in the middle of the row stream, and with scrambled inputs after start show that only the captured state decides the result.

// File: rtl/i16_pkg.sv
package i16_pkg;

    typedef enum logic [1:0] {
        MODE_VERT = 2'd0,
        MODE_HORZ = 2'd1,
        MODE_DC   = 2'd2
    } mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ROWS = 2'd1,
        ST_PICK = 2'd2
    } state_e;

    localparam int unsigned NUM_MODES = 3;
    localparam int unsigned COST_W    = 32;
    localparam logic [COST_W-1:0] COST_SENTINEL = COST_W'(1) << 30;

    // positions inside the availability word
    localparam int unsigned AVL_LEFT_BIT = 0;
    localparam int unsigned AVL_TOP_BIT  = 2;

endpackage

// File: rtl/i16_dc_calc.sv
module i16_dc_calc
    import i16_pkg::*;
#(
    parameter int unsigned N     = 16,
    parameter int unsigned PIX_W = 8,
    parameter int unsigned AVL_W = 4
) (
    input  logic [(2*N+1)*PIX_W-1:0] nbr_i,
    input  logic [AVL_W-1:0]         avail_i,
    output logic [PIX_W-1:0]         dc_o
);
    localparam int unsigned LOG_N      = $clog2(N);
    localparam int unsigned SUM_W      = PIX_W + $clog2(2*N) + 1;
    localparam int unsigned SHIFT_BASE = LOG_N - 1;

    logic [SUM_W-1:0] sum;
    logic [SUM_W-1:0] shifted;
    logic [1:0]       sides;
    logic             has_left;
    logic             has_top;

    always_comb begin
        has_left = avail_i[AVL_LEFT_BIT];
        has_top  = avail_i[AVL_TOP_BIT];
        sum      = '0;
        for (int i = 0; i < N; i++) begin
            if (has_left) sum = sum + SUM_W'(nbr_i[i*PIX_W +: PIX_W]);
            if (has_top)  sum = sum + SUM_W'(nbr_i[(N+1+i)*PIX_W +: PIX_W]);
        end
        sides   = {1'b0, has_left} + {1'b0, has_top};
        sum     = sum + SUM_W'(sides) * SUM_W'(N/2);
        shifted = sum >> (SHIFT_BASE + int'(sides));
        if (avail_i == '0) begin
            dc_o = PIX_W'(1) << (PIX_W - 1);
        end else if (|shifted[SUM_W-1:PIX_W]) begin
            dc_o = '1;
        end else begin
            dc_o = shifted[PIX_W-1:0];
        end
    end
endmodule

// File: rtl/i16_row_sad.sv
module i16_row_sad #(
    parameter int unsigned N     = 16,
    parameter int unsigned PIX_W = 8,
    parameter int unsigned OUT_W = PIX_W + $clog2(N)
) (
    input  logic [N*PIX_W-1:0] src_row_i,
    input  logic [N*PIX_W-1:0] pred_row_i,
    output logic [OUT_W-1:0]   row_sad_o
);
    logic [N-1:0][PIX_W-1:0] diff;

    for (genvar g = 0; g < N; g++) begin : g_pix
        logic [PIX_W-1:0] a;
        logic [PIX_W-1:0] b;
        assign a       = src_row_i[g*PIX_W +: PIX_W];
        assign b       = pred_row_i[g*PIX_W +: PIX_W];
        assign diff[g] = (a > b) ? (a - b) : (b - a);
    end

    always_comb begin
        row_sad_o = '0;
        for (int i = 0; i < N; i++) begin
            row_sad_o = row_sad_o + OUT_W'(diff[i]);
        end
    end
endmodule

// File: rtl/i16_pick.sv
module i16_pick
    import i16_pkg::*;
#(
    parameter int unsigned ACC_W = 16
) (
    input  logic [NUM_MODES-1:0][ACC_W-1:0] sad_i,
    input  logic [NUM_MODES-1:0]            mask_i,
    output mode_e                           mode_o,
    output logic [COST_W-1:0]               cost_o
);
    logic [NUM_MODES-1:0][COST_W-1:0] cost;

    for (genvar m = 0; m < NUM_MODES; m++) begin : g_cost
        assign cost[m] = mask_i[m] ? COST_W'(sad_i[m]) : COST_SENTINEL;
    end

    always_comb begin
        if (cost[MODE_VERT] <= cost[MODE_HORZ] && cost[MODE_VERT] <= cost[MODE_DC]) begin
            mode_o = MODE_VERT;
            cost_o = cost[MODE_VERT];
        end else if (cost[MODE_HORZ] <= cost[MODE_DC]) begin
            mode_o = MODE_HORZ;
            cost_o = cost[MODE_HORZ];
        end else begin
            mode_o = MODE_DC;
            cost_o = cost[MODE_DC];
        end
    end
endmodule

// File: rtl/i16_mode_decide.sv
module i16_mode_decide
    import i16_pkg::*;
#(
    parameter int unsigned N     = 16,
    parameter int unsigned PIX_W = 8,
    parameter int unsigned AVL_W = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [(2*N+1)*PIX_W-1:0] nbr_i,
    input  logic [AVL_W-1:0]         avail_i,
    input  logic [NUM_MODES-1:0]     mask_i,
    input  logic                     row_valid,
    input  logic [N*PIX_W-1:0]       row_data,
    output logic                     row_ready,
    output logic                     done,
    output logic [1:0]               best_mode,
    output logic [COST_W-1:0]        best_sad
);
    localparam int unsigned NB_W      = (2*N+1)*PIX_W;
    localparam int unsigned ROW_BITS  = N*PIX_W;
    localparam int unsigned CNT_W     = $clog2(N);
    localparam int unsigned ROW_SAD_W = PIX_W + $clog2(N);
    localparam int unsigned MAX_SAD   = N*N*((1 << PIX_W) - 1);
    localparam int unsigned ACC_W     = $clog2(MAX_SAD + 1);

    typedef struct packed {
        state_e                           state;
        logic [NB_W-1:0]                  nbr;
        logic [NUM_MODES-1:0]             mask;
        logic [PIX_W-1:0]                 dc;
        logic [CNT_W-1:0]                 row;
        logic [NUM_MODES-1:0][ACC_W-1:0]  acc;
        logic                             done;
        logic [1:0]                       mode;
        logic [COST_W-1:0]                cost;
    } regs_t;

    regs_t r_d, r_q;

    logic [PIX_W-1:0]                    dc_now;
    logic [CNT_W-1:0]                    left_idx;
    logic [PIX_W-1:0]                    left_pix;
    logic [NUM_MODES-1:0][ROW_BITS-1:0]  pred;
    logic [NUM_MODES-1:0][ROW_SAD_W-1:0] row_sad;
    mode_e                               pick_mode;
    logic [COST_W-1:0]                   pick_cost;

    // flat value from the live inputs, captured at start
    i16_dc_calc #(.N(N), .PIX_W(PIX_W), .AVL_W(AVL_W)) i_dc (
        .nbr_i   (nbr_i),
        .avail_i (avail_i),
        .dc_o    (dc_now)
    );

    // predictor rows for the row being taken; left pixels are stored bottom-up
    assign left_idx        = CNT_W'(N - 1) - r_q.row;
    assign left_pix        = r_q.nbr[int'(left_idx)*PIX_W +: PIX_W];
    assign pred[MODE_VERT] = r_q.nbr[(N+1)*PIX_W +: ROW_BITS];
    assign pred[MODE_HORZ] = {N{left_pix}};
    assign pred[MODE_DC]   = {N{r_q.dc}};

    for (genvar m = 0; m < NUM_MODES; m++) begin : g_sad
        i16_row_sad #(.N(N), .PIX_W(PIX_W), .OUT_W(ROW_SAD_W)) i_row (
            .src_row_i  (row_data),
            .pred_row_i (pred[m]),
            .row_sad_o  (row_sad[m])
        );
    end

    i16_pick #(.ACC_W(ACC_W)) i_pick (
        .sad_i  (r_q.acc),
        .mask_i (r_q.mask),
        .mode_o (pick_mode),
        .cost_o (pick_cost)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (start) begin
                    r_d.state = ST_ROWS;
                    r_d.nbr   = nbr_i;
                    r_d.mask  = mask_i;
                    r_d.dc    = dc_now;
                    r_d.row   = '0;
                    r_d.acc   = '0;
                end
            end
            ST_ROWS: begin
                if (row_valid) begin
                    for (int m = 0; m < NUM_MODES; m++) begin
                        r_d.acc[m] = r_q.acc[m] + ACC_W'(row_sad[m]);
                    end
                    if (r_q.row == CNT_W'(N - 1)) begin
                        r_d.state = ST_PICK;
                    end else begin
                        r_d.row = r_q.row + CNT_W'(1);
                    end
                end
            end
            ST_PICK: begin
                r_d.mode  = pick_mode;
                r_d.cost  = pick_cost;
                r_d.done  = 1'b1;
                r_d.state = ST_IDLE;
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign row_ready = (r_q.state == ST_ROWS);
    assign done      = r_q.done;
    assign best_mode = r_q.mode;
    assign best_sad  = r_q.cost;

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R11
    AST_NO_READY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !row_ready); // R3
    AST_CAPTURE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_ROWS) |=> ($stable(r_q.mask) && $stable(r_q.dc) && $stable(r_q.nbr))); // R2
    AST_ACC_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_ROWS) |=> (r_q.acc[MODE_VERT] >= $past(r_q.acc[MODE_VERT]))); // R4
    AST_MODE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (best_mode <= 2'd2)); // R12
    AST_SENTINEL_COST: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !r_q.mask[best_mode]) |-> (best_sad == COST_SENTINEL)); // R9
    AST_REAL_COST_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (done && r_q.mask[best_mode]) |-> (best_sad <= COST_W'(MAX_SAD))); // R12
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!done && r_q.state != ST_PICK) |=> $stable(best_sad)); // R11

endmodule

// File: tb/test_i16_mode_decide.sv
module test_i16_mode_decide;

    localparam int N = 16;
    localparam logic [31:0] SENT = 32'd1 << 30;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [33*8-1:0]   nbr_i = '0;
    logic [3:0]        avail_i = '0;
    logic [2:0]        mask_i = '0;
    logic              row_valid = 1'b0;
    logic [N*8-1:0]    row_data = '0;
    logic              row_ready;
    logic              done;
    logic [1:0]        best_mode;
    logic [31:0]       best_sad;

    always #4 clk = ~clk; // 125 MHz

    i16_mode_decide i_i16_mode_decide (
        .clk(clk), .rst_n(rst_n), .start(start), .nbr_i(nbr_i),
        .avail_i(avail_i), .mask_i(mask_i), .row_valid(row_valid),
        .row_data(row_data), .row_ready(row_ready), .done(done),
        .best_mode(best_mode), .best_sad(best_sad)
    );

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // kind: 0 source copies top row, 1 rows copy left pixel, 2 flat, 3 pattern
    typedef struct packed {
        logic [1:0] kind;
        logic [7:0] fill;
        logic [7:0] seed;
        logic [3:0] avail;
        logic [2:0] mask;
        logic       gaps;
        logic [1:0] exp_mode; // 3: take the reference model's choice
        logic [3:0] req;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 8'd0,   8'd1, 4'd5, 3'd7, 1'b0, 2'd0, 4'd4},  // R4 vertical exact
        '{2'd1, 8'd0,   8'd2, 4'd5, 3'd7, 1'b1, 2'd1, 4'd5},  // R5 horizontal exact, gaps
        '{2'd2, 8'd100, 8'd0, 4'd5, 3'd7, 1'b0, 2'd0, 4'd10}, // R10 three-way tie
        '{2'd2, 8'd100, 8'd0, 4'd5, 3'd6, 1'b1, 2'd1, 4'd10}, // R10 tie horz over dc
        '{2'd2, 8'd100, 8'd0, 4'd5, 3'd4, 1'b0, 2'd2, 4'd6},  // R6 dc only
        '{2'd2, 8'd100, 8'd0, 4'd5, 3'd0, 1'b0, 2'd0, 4'd9},  // R9 all masked
        '{2'd3, 8'd0,   8'd3, 4'd5, 3'd4, 1'b0, 2'd2, 4'd6},  // R6 both sides
        '{2'd3, 8'd0,   8'd4, 4'd1, 3'd4, 1'b1, 2'd2, 4'd7},  // R7 left only
        '{2'd3, 8'd0,   8'd5, 4'd4, 3'd4, 1'b0, 2'd2, 4'd7},  // R7 top only
        '{2'd3, 8'd0,   8'd8, 4'd0, 3'd4, 1'b0, 2'd2, 4'd8},  // R8 nothing at all
        '{2'd3, 8'd0,   8'd9, 4'd2, 3'd4, 1'b1, 2'd2, 4'd8},  // R8 word nonzero, no sides
        '{2'd3, 8'd0,   8'd6, 4'd5, 3'd7, 1'b0, 2'd3, 4'd12}, // R12 free choice
        '{2'd0, 8'd0,   8'd7, 4'd5, 3'd6, 1'b0, 2'd3, 4'd9},  // R9 exact mode masked
        '{2'd3, 8'd0,   8'd10,4'd5, 3'd2, 1'b0, 2'd1, 4'd9},  // R9 horz only
        '{2'd2, 8'd128, 8'd0, 4'd0, 3'd4, 1'b0, 2'd2, 4'd8}   // R8 flat 128
    };

    logic [7:0] nb  [33];
    logic [7:0] src [N][N];

    function automatic int absd(input int a, input int b);
        return (a > b) ? a - b : b - a;
    endfunction

    task automatic build(input vec_t v);
        for (int i = 0; i < 33; i++)
            nb[i] = (v.kind == 2'd2) ? v.fill : 8'((i*37 + int'(v.seed)*13 + 9) & 255);
        for (int r = 0; r < N; r++)
            for (int c = 0; c < N; c++)
                case (v.kind)
                    2'd0: src[r][c] = nb[17+c];
                    2'd1: src[r][c] = nb[15-r];
                    2'd2: src[r][c] = v.fill;
                    default: src[r][c] = 8'((r*29 + c*53 + int'(v.seed)*71 + r*c*7) & 255);
                endcase
    endtask

    task automatic model(input logic [3:0] av, input logic [2:0] mk,
                         output int mode, output longint cost);
        longint c [3];
        int dcv, s, sides;
        s = 0; sides = 0;
        if (av[0]) begin sides++; for (int i = 0; i < 16; i++) s += nb[i]; end
        if (av[2]) begin sides++; for (int i = 0; i < 16; i++) s += nb[17+i]; end
        if (av == 4'd0) dcv = 128;
        else if (sides == 0) dcv = 0;
        else if (sides == 1) dcv = (s + 8) / 16;
        else dcv = (s + 16) / 32;
        c[0] = 0; c[1] = 0; c[2] = 0;
        for (int r = 0; r < N; r++)
            for (int cc = 0; cc < N; cc++) begin
                c[0] += absd(src[r][cc], nb[17+cc]);
                c[1] += absd(src[r][cc], nb[15-r]);
                c[2] += absd(src[r][cc], dcv);
            end
        for (int m = 0; m < 3; m++) if (!mk[m]) c[m] = SENT;
        if (c[0] <= c[1] && c[0] <= c[2]) begin mode = 0; cost = c[0]; end
        else if (c[1] <= c[2]) begin mode = 1; cost = c[1]; end
        else begin mode = 2; cost = c[2]; end
    endtask

    task automatic run_vec(input vec_t v, input bit busy_start);
        int em;
        longint ec;
        logic [33*8-1:0] packed_nb;
        logic [N*8-1:0]  packed_row;
        logic [1:0]      m_hold;
        logic [31:0]     s_hold;
        string tag;
        tag = $sformatf("R%0d", v.req);
        build(v);
        model(v.avail, v.mask, em, ec);
        for (int i = 0; i < 33; i++) packed_nb[i*8 +: 8] = nb[i];
        @(negedge clk);
        start = 1'b1; nbr_i = packed_nb; avail_i = v.avail; mask_i = v.mask;
        @(negedge clk);
        start = 1'b0; nbr_i = ~packed_nb; avail_i = ~v.avail; mask_i = ~v.mask; // R2 scramble
        for (int r = 0; r < N; r++) begin
            if (v.gaps && r[0]) begin
                row_valid = 1'b0; row_data = '1;
                @(negedge clk);
            end
            for (int c = 0; c < N; c++) packed_row[c*8 +: 8] = src[r][c];
            row_valid = 1'b1; row_data = packed_row;
            if (busy_start && r == 5) start = 1'b1;
            chk(row_ready == 1'b1, "R3 ready during rows", row_ready, 1);
            @(negedge clk);
            start = 1'b0;
        end
        row_valid = 1'b0;
        chk(row_ready == 1'b0, "R3 ready after last row", row_ready, 0);
        chk(done == 1'b0, "R11 done too early", done, 0);
        @(negedge clk);
        chk(done == 1'b1, "R11 done pulse", done, 1);
        chk(best_mode == 2'(em), {tag, " mode vs model"}, best_mode, em);
        chk(best_sad == 32'(ec), {tag, " cost vs model"}, best_sad, ec);
        if (v.exp_mode != 2'd3)
            chk(best_mode == v.exp_mode, {tag, " R12 mode code"}, best_mode, v.exp_mode);
        m_hold = best_mode; s_hold = best_sad;
        @(negedge clk);
        chk(done == 1'b0, "R11 done single cycle", done, 0);
        chk(best_mode == m_hold && best_sad == s_hold, "R11 result held", best_sad, s_hold);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        chk(done == 1'b0 && row_ready == 1'b0, "R1 reset handshake", {done, row_ready}, 0);
        chk(best_mode == 2'd0 && best_sad == 32'd0, "R1 reset result", best_sad, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(row_ready == 1'b0 && done == 1'b0, "R1 idle after reset", row_ready, 0);
        // R3 rows offered while idle are not taken
        row_valid = 1'b1; row_data = '1;
        repeat (3) begin
            @(negedge clk);
            chk(row_ready == 1'b0 && done == 1'b0, "R3 idle rows ignored", row_ready, 0);
        end
        row_valid = 1'b0;
        for (int k = 0; k < NV; k++) run_vec(VECS[k], 1'b0);
        // R2 a second start in the middle of the row stream changes nothing
        run_vec(VECS[6], 1'b1);
        run_vec(VECS[1], 1'b1);
        finished = 1;
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog R11 actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", checks, fails);
            $finish;
        end
    end

endmodule